// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores received frames in a circular region of local byte memory that is organised in 256-byte pages. The region is bounded by a first page and an end page (the end page is one past the last usable page). The host owns a boundary page that marks how far it has consumed the ring. The block owns the current page, which is where the next frame will be placed. A frame source announces each frame with a request that carries its length and a flag telling whether the destination is a group address. If the block takes the frame, it writes a 4-byte link header at the start of the current page. It then writes the payload one byte per clock, pulled through a ready/valid handshake, wrapping at the end of the ring. Frames shorter than the minimum size are filled out with zero bytes.

When the last byte has been written, the block emits a one-cycle done pulse. It then moves the current page to the first page after the stored frame and raises a sticky receive interrupt flag. A request is refused with a drop pulse in three cases: reception is halted, a frame is already being stored, or the free space between the current page and the boundary is smaller than one worst-case frame.

The controller has five named states:
- IDLE waits for a request. On a take it moves to HDR (transition *take*).
- HDR writes the four header bytes. It then moves to DATA, or straight to PAD for a zero-length frame (transition *hdr_end*).
- DATA writes one payload byte for each beat it accepts. After the last byte it moves to PAD if the frame is short, otherwise to DONE (transition *payload_end*).
- PAD writes zero bytes until the minimum length is reached, then moves to DONE (transition *pad_end*).
- DONE lasts one cycle, commits the current page and the interrupt, and returns to IDLE (transition *commit*).

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, cur_pg is 0, rx_irq is 0, rx_stat is 0, and mem_we, frm_done, frm_take, frm_drop and in_ready are all 0.
- R2: A taken frame first writes 4 header bytes, at byte addresses cur_pg*256+0 to cur_pg*256+3, in this order: status byte, next page, low byte of total, high byte of total. Total is max(frm_len,60)+4.
- R3: After the header, the block writes exactly frm_len payload bytes at consecutive addresses starting at cur_pg*256+4, one per cycle in which in_ready and in_valid are both high. in_ready is high only while payload bytes are still expected.
- R4: A frame with frm_len below 60 is followed by zero bytes until 60 bytes have been stored after the header.
- R5: Any write whose address would reach ring_end_pg*256 goes to ring_first_pg*256 instead.
- R6: The next page is cur_pg + ceil((total+4)/256). If that value is at or above ring_end_pg, (ring_end_pg − ring_first_pg) is subtracted from it. cur_pg takes this value in the cycle after frm_done.
- R7: Free space in bytes is computed as follows. If cur_pg ≤ host_bnd_pg, it is 256·(host_bnd_pg − cur_pg). Otherwise it is 256·((ring_end_pg − ring_first_pg) − (cur_pg − host_bnd_pg)). A request is refused (frm_drop high in the request cycle, no writes) when the free space is below 1518.
- R8: A request made while rx_halt is high is refused with frm_drop and causes no writes.
- R9: A request made while a frame is being stored is refused with frm_drop. It does not change the write stream of the frame in progress.
- R10: The status byte is 0x01, plus 0x20 when frm_group is high. rx_stat shows the status of the last taken frame.
- R11: frm_done is a single-cycle pulse in the cycle after the last memory write. rx_irq becomes 1 in the following cycle and stays 1 until irq_ack clears it.
- R12: cur_wr loads cur_wr_pg into cur_pg on the next clock while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_first_pg | input | 8 | First page of the ring |
| ring_end_pg | input | 8 | Page one past the last ring page |
| host_bnd_pg | input | 8 | Host-owned boundary page |
| rx_halt | input | 1 | Reception halted; all requests are refused |
| cur_wr | input | 1 | Load strobe for the current page |
| cur_wr_pg | input | 8 | Value to load into the current page |
| irq_ack | input | 1 | Clears the receive interrupt flag |
| frm_req | input | 1 | Frame start request |
| frm_len | input | 16 | Frame length in bytes, valid with frm_req |
| frm_group | input | 1 | Destination is a group address, valid with frm_req |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block accepts a payload byte |
| frm_take | output | 1 | Request taken (combinational, request cycle) |
| frm_drop | output | 1 | Request refused (combinational, request cycle) |
| frm_done | output | 1 | Frame fully stored |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | 8 | Current page |
| rx_stat | output | 8 | Status byte of the last taken frame |
| rx_irq | output | 1 | Sticky receive interrupt flag |

## Verification
Several properties are checked by assertions on every cycle:
- requests made under halt or while busy are always refused;
- padding bytes are always zero;
- payload and padding writes never leave the ring;
- every done pulse lasts one cycle and is followed by the interrupt flag.

Other behaviour can only be shown by the bench scenarios, which compare the full write stream against a behavioural model:
- the exact header contents;
- the byte order across a wrap;
- the next-page arithmetic when the result lands exactly on the end page;
- the free-space threshold on both sides of the 1518-byte limit, in both the unwrapped and the wrapped case.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAD,
        ST_DONE
    } rxr_state_t;

    localparam logic [7:0] STAT_GOOD  = 8'h01;
    localparam logic [7:0] STAT_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 8,
    parameter int RESERVE = 1518
) (
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] end_pg,
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] bnd_pg,
    output logic              no_room
);
    localparam int W = PAGE_W + OFF_W + 2;

    logic [W-1:0] cur_a, bnd_a, first_a, end_a, avail;

    always_comb begin
        cur_a   = W'({cur_pg,   {OFF_W{1'b0}}});
        bnd_a   = W'({bnd_pg,   {OFF_W{1'b0}}});
        first_a = W'({first_pg, {OFF_W{1'b0}}});
        end_a   = W'({end_pg,   {OFF_W{1'b0}}});
        if (cur_a <= bnd_a)
            avail = bnd_a - cur_a;
        else
            avail = (end_a - first_a) - (cur_a - bnd_a);
        no_room = avail < W'(RESERVE);
    end
endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 8,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60,
    parameter int HDR_LEN = 4,
    parameter int TAIL_LEN = 4
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] end_pg,
    input  logic [LEN_W-1:0]  frame_len,
    output logic [PAGE_W-1:0] next_pg,
    output logic [LEN_W-1:0]  total_len
);
    localparam int W = LEN_W + 2;
    localparam int ROUND = TAIL_LEN + (1 << OFF_W) - 1;

    logic [LEN_W-1:0] padded;
    logic [W-1:0]     span, pages, sum, end_w, first_w, wrapped;

    always_comb begin
        padded    = (frame_len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : frame_len;
        total_len = padded + LEN_W'(HDR_LEN);
        span      = W'(total_len) + W'(ROUND);
        pages     = span >> OFF_W;
        sum       = W'(cur_pg) + pages;
        end_w     = W'(end_pg);
        first_w   = W'(first_pg);
        wrapped   = (sum >= end_w) ? (sum - (end_w - first_w)) : sum;
        next_pg   = wrapped[PAGE_W-1:0];
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 8,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 60,
    parameter int RESERVE = 1518
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PAGE_W-1:0]         ring_first_pg,
    input  logic [PAGE_W-1:0]         ring_end_pg,
    input  logic [PAGE_W-1:0]         host_bnd_pg,
    input  logic                      rx_halt,
    input  logic                      cur_wr,
    input  logic [PAGE_W-1:0]         cur_wr_pg,
    input  logic                      irq_ack,
    input  logic                      frm_req,
    input  logic [LEN_W-1:0]          frm_len,
    input  logic                      frm_group,
    input  logic                      in_valid,
    input  logic [7:0]                in_data,
    output logic                      in_ready,
    output logic                      frm_take,
    output logic                      frm_drop,
    output logic                      frm_done,
    output logic                      mem_we,
    output logic [PAGE_W+OFF_W-1:0]   mem_addr,
    output logic [7:0]                mem_wdata,
    output logic [PAGE_W-1:0]         cur_pg,
    output logic [7:0]                rx_stat,
    output logic                      rx_irq
);
    localparam int AW       = PAGE_W + OFF_W;
    localparam int HDR_LEN  = 4;
    localparam int TAIL_LEN = 4;

    rxr_state_t        state, state_nx;
    logic [1:0]        hidx;
    logic [LEN_W-1:0]  cnt, len_q, tot_q, tot_nx;
    logic [PAGE_W-1:0] cur_q, next_q, next_nx;
    logic [AW-1:0]     wptr, wptr_inc, cur_a, first_a, end_a;
    logic [7:0]        stat_q, hdr_byte;
    logic              irq_q, no_room, wr_fire, last_data, pad_end;

    rxr_space_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .RESERVE(RESERVE)) space_i (
        .first_pg(ring_first_pg), .end_pg(ring_end_pg),
        .cur_pg(cur_q), .bnd_pg(host_bnd_pg), .no_room(no_room)
    );

    rxr_next_calc #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN),
                    .HDR_LEN(HDR_LEN), .TAIL_LEN(TAIL_LEN)) next_i (
        .cur_pg(cur_q), .first_pg(ring_first_pg), .end_pg(ring_end_pg),
        .frame_len(frm_len), .next_pg(next_nx), .total_len(tot_nx)
    );

    assign cur_a     = {cur_q, {OFF_W{1'b0}}};
    assign first_a   = {ring_first_pg, {OFF_W{1'b0}}};
    assign end_a     = {ring_end_pg, {OFF_W{1'b0}}};
    assign wptr_inc  = (wptr + AW'(1) == end_a) ? first_a : wptr + AW'(1);
    assign frm_take  = frm_req && (state == ST_IDLE) && !rx_halt && !no_room;
    assign frm_drop  = frm_req && !frm_take;
    assign wr_fire   = ((state == ST_DATA) && in_valid) || (state == ST_PAD);
    assign last_data = (cnt + LEN_W'(1)) == len_q;
    assign pad_end   = (cnt + LEN_W'(1)) >= LEN_W'(MIN_LEN);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (frm_take) state_nx = ST_HDR;
            ST_HDR:  if (hidx == 2'd3)
                         state_nx = (len_q == '0) ? ST_PAD : ST_DATA;
            ST_DATA: if (in_valid && last_data)
                         state_nx = (len_q < LEN_W'(MIN_LEN)) ? ST_PAD : ST_DONE;
            ST_PAD:  if (pad_end) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (hidx)
            2'd0:    hdr_byte = stat_q;
            2'd1:    hdr_byte = 8'(next_q);
            2'd2:    hdr_byte = tot_q[7:0];
            default: hdr_byte = 8'(tot_q >> 8);
        endcase
        in_ready  = (state == ST_DATA);
        frm_done  = (state == ST_DONE);
        mem_we    = (state == ST_HDR) || wr_fire;
        mem_addr  = (state == ST_HDR) ? (cur_a + AW'(hidx)) : wptr;
        unique case (state)
            ST_HDR:  mem_wdata = hdr_byte;
            ST_DATA: mem_wdata = in_data;
            default: mem_wdata = 8'h00;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hidx   <= '0;
            cnt    <= '0;
            len_q  <= '0;
            tot_q  <= '0;
            next_q <= '0;
            wptr   <= '0;
            cur_q  <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (frm_take) begin
                len_q  <= frm_len;
                tot_q  <= tot_nx;
                next_q <= next_nx;
                stat_q <= STAT_GOOD | (frm_group ? STAT_GROUP : 8'h00);
                wptr   <= cur_a + AW'(HDR_LEN);
                hidx   <= '0;
                cnt    <= '0;
            end
            if (state == ST_HDR) hidx <= hidx + 2'd1;
            if (wr_fire) begin
                cnt  <= cnt + LEN_W'(1);
                wptr <= wptr_inc;
            end
            if (state == ST_DONE)                 cur_q <= next_q;
            else if (cur_wr && state == ST_IDLE)  cur_q <= cur_wr_pg;
            if (state == ST_DONE)  irq_q <= 1'b1;
            else if (irq_ack)      irq_q <= 1'b0;
        end
    end

    assign cur_pg  = cur_q;
    assign rx_stat = stat_q;
    assign rx_irq  = irq_q;

    assert_halt_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req && rx_halt |-> frm_drop && !frm_take);
    assert_busy_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_req && state != ST_IDLE |-> frm_drop);
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && state == ST_PAD |-> mem_wdata == 8'h00);
    assert_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && (state == ST_DATA || state == ST_PAD) |-> mem_addr >= first_a && mem_addr < end_a);
    assert_done_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> rx_irq);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done);
endmodule

// File: tb/rx_ring_writer_tb_top.sv
module rx_ring_writer_tb_top;
    logic        clk = 0, rst_n = 0;
    logic [7:0]  ring_first_pg = 0, ring_end_pg = 0, host_bnd_pg = 0, cur_wr_pg = 0;
    logic        rx_halt = 0, cur_wr = 0, irq_ack = 0, frm_req = 0, frm_group = 0;
    logic [15:0] frm_len = 0;
    logic        in_valid = 0;
    logic [7:0]  in_data = 0;
    logic        in_ready, frm_take, frm_drop, frm_done, mem_we, rx_irq;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, cur_pg, rx_stat;

    int total = 0, bad = 0;
    int exp_a[$], exp_d[$];
    int model_cur = 0;
    bit prev_we = 0;
    bit finished = 0;

    rx_ring_writer dut_i (.*);

    always #10 clk = ~clk;

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference write stream comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_done)
                chk(prev_we && exp_a.size() == 0, "R11 done after last write",
                    int'(prev_we), 1);
            if (mem_we) begin
                if (exp_a.size() == 0) begin
                    chk(0, "R3 unexpected write", int'(mem_addr), -1);
                end else begin
                    chk(int'(mem_addr) == exp_a[0] && int'(mem_wdata) == exp_d[0],
                        "R2/R3 write stream",
                        (int'(mem_addr) << 8) | int'(mem_wdata), (exp_a[0] << 8) | exp_d[0]);
                    void'(exp_a.pop_front());
                    void'(exp_d.pop_front());
                end
            end
            prev_we = mem_we;
        end
    end

    function automatic int pbyte(int seed, int i);
        return (seed + i * 7) & 255;
    endfunction

    task automatic load_cur(int pg);
        @(negedge clk); cur_wr = 1; cur_wr_pg = 8'(pg);
        @(negedge clk); cur_wr = 0;
        model_cur = pg;
        chk(int'(cur_pg) == pg, "R12 current page load", int'(cur_pg), pg);
    endtask

    task automatic send_frame(int len, bit grp, int seed, bit want, bit probe, string tag);
        int st, padded, tl, nx, a, p, sa, ea, stat, i, cyc;
        @(negedge clk);
        frm_req = 1; frm_len = 16'(len); frm_group = grp;
        #1;
        chk(frm_take == want && frm_drop == !want, tag, int'(frm_take), int'(want));
        if (want) begin
            sa = int'(ring_first_pg) * 256; ea = int'(ring_end_pg) * 256;
            stat = 1 | (grp ? 32 : 0);
            padded = len < 60 ? 60 : len;
            tl = padded + 4;
            nx = model_cur + (tl + 4 + 255) / 256;
            if (nx >= int'(ring_end_pg)) nx -= int'(ring_end_pg) - int'(ring_first_pg);
            a = model_cur * 256;
            exp_a.push_back(a);     exp_d.push_back(stat);
            exp_a.push_back(a + 1); exp_d.push_back(nx & 255);
            exp_a.push_back(a + 2); exp_d.push_back(tl & 255);
            exp_a.push_back(a + 3); exp_d.push_back(tl >> 8);
            p = a + 4;
            for (int k = 0; k < padded; k++) begin
                exp_a.push_back(p);
                exp_d.push_back(k < len ? pbyte(seed, k) : 0);
                p++;
                if (p == ea) p = sa;
            end
            @(negedge clk); frm_req = 0;
            i = 0; cyc = 0;
            while (i < len && cyc < 5000) begin
                if (cyc != 0) @(negedge clk);
                frm_req = 0;
                cyc++;
                if (cyc % 7 == 3) begin
                    in_valid = 0;
                end else if (in_ready) begin
                    in_valid = 1; in_data = 8'(pbyte(seed, i));
                    if (probe && i == 5) begin
                        frm_req = 1; frm_len = 16'd100;
                        #1;
                        chk(frm_drop && !frm_take, "R9 busy request refused", int'(frm_drop), 1);
                    end
                    i++;
                end else begin
                    in_valid = 0;
                end
            end
            @(negedge clk); in_valid = 0; frm_req = 0;
            cyc = 0;
            while (!frm_done && cyc < 500) begin @(negedge clk); cyc++; end
            chk(frm_done, "R11 done pulse", int'(frm_done), 1);
            @(negedge clk);
            chk(int'(cur_pg) == nx, "R6 next page", int'(cur_pg), nx);
            chk(rx_irq == 1, "R11 irq set", int'(rx_irq), 1);
            chk(int'(rx_stat) == stat, "R10 status", int'(rx_stat), stat);
            model_cur = nx;
        end else begin
            @(negedge clk); frm_req = 0;
            repeat (3) @(negedge clk);
            chk(!mem_we && int'(cur_pg) == model_cur, {tag, " no effect"}, int'(cur_pg), model_cur);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cur_pg == 0 && !rx_irq && rx_stat == 0 && !mem_we && !frm_done && !in_ready,
            "R1 reset state", int'(cur_pg), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!mem_we && !frm_take && !frm_drop && !in_ready, "R1 idle outputs", int'(mem_we), 0);
        ring_first_pg = 8'h40; ring_end_pg = 8'h80;
        load_cur(8'h40);
        host_bnd_pg = 8'h40;
        send_frame(20, 1, 3, 0, 0, "R7 zero space refused");
        host_bnd_pg = 8'h45;
        send_frame(20, 1, 3, 0, 0, "R7 1280 bytes refused");
        host_bnd_pg = 8'h46;
        send_frame(20, 1, 3, 1, 0, "R7 1536 bytes taken, R4 short frame");
        host_bnd_pg = 8'h60;
        send_frame(600, 0, 11, 1, 1, "R3 long frame taken");
        send_frame(60, 0, 90, 1, 0, "R4 exact minimum taken");
        rx_halt = 1;
        send_frame(60, 0, 1, 0, 0, "R8 halted refused");
        rx_halt = 0;
        load_cur(8'h7C);
        host_bnd_pg = 8'h41;
        send_frame(100, 0, 5, 0, 0, "R7 wrapped 1280 refused");
        host_bnd_pg = 8'h42;
        send_frame(100, 1, 5, 1, 0, "R7 wrapped 1536 taken");
        load_cur(8'h7F);
        host_bnd_pg = 8'h70;
        send_frame(200, 0, 17, 1, 0, "R6 next lands on end page");
        load_cur(8'h7E);
        send_frame(700, 1, 29, 1, 0, "R5 payload wraps");
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk(rx_irq == 0, "R11 irq cleared", int'(rx_irq), 0);
        chk(exp_a.size() == 0, "R3 all writes seen", exp_a.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule